// File: doc/BRIEF.md
# Tone-Pair Steering Validator

This block turns a raw "tone pair seen" indication from a tone detector into validated received characters. The detector drives an early-steering level that is high while it recognises a valid pair, together with the 4-bit code of that pair. The validator times that level with two independent digital counters clocked by a shared timebase enable: one for how long the pair must persist before it counts, and one for how long silence must persist before another character may be accepted. Short bursts are discarded and brief dropouts inside a tone are bridged.

When a tone passes its presence guard, the validator copies the code into a receive register, fires a one-cycle new-data pulse for interrupt logic and sets a receive-full flag that a status read clears. A guard output follows the tone while it is held. A delayed-steering flag rises a fixed number of clock cycles after the copy, so anything that reacts to the flag sees stable data. While call-progress mode is selected, nothing is registered.

Top module: `tone_steer_validator`

## Requirements
- R1: After reset, rx_code is 0 and rx_new, rx_full, guard_out and dly_steer are all low.
- R2: When est_in is sampled high on present_ticks consecutive timebase ticks with the block idle, the clock edge after the last of those samples loads rx_code with the sampled 4-bit code and raises rx_new for exactly one cycle.
- R3: A tone sampled high on fewer than present_ticks consecutive ticks registers nothing: rx_code keeps its old value and rx_new stays low.
- R4: guard_out is high from the registration edge for as long as est_in stays sampled high, and low once est_in is sampled low.
- R5: dly_steer rises SETTLE_CYC clock cycles after the registration edge, never in the same cycle as an rx_code change.
- R6: A dropout in which est_in is sampled low on fewer than absent_ticks consecutive ticks leaves dly_steer high, rx_code unchanged and produces no rx_new.
- R7: After a registered tone, once est_in is sampled low on absent_ticks consecutive ticks, dly_steer falls on the next clock edge and a new tone can be registered.
- R8: rx_full is set by a registration and cleared by a one-cycle stat_rd; when both happen in the same cycle, rx_full stays set.
- R9: While cp_mode is high, no tone is registered, however long it lasts.
- R10: Both guard counters advance only on cycles where tick is high; with tick held low no tone is registered.
- R11: A tone held far longer than present_ticks produces exactly one registration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable for both guard counters |
| est_in | input | 1 | Early-steering level from the tone detector |
| tone_code | input | CODE_W | Code of the detected tone pair |
| cp_mode | input | 1 | Call-progress mode; suppresses registration |
| stat_rd | input | 1 | Status read strobe; clears rx_full |
| present_ticks | input | CNT_W | Tone-present guard length in ticks (at least 1) |
| absent_ticks | input | CNT_W | Tone-absent guard length in ticks (at least 1) |
| rx_code | output | CODE_W | Receive register |
| rx_new | output | 1 | One-cycle pulse on registration |
| rx_full | output | 1 | Receive register holds unread data |
| guard_out | output | 1 | Guard output, high while a registered tone is present |
| dly_steer | output | 1 | Delayed-steering flag |

## Verification
With the tone starting on clock edge k and tick held high, registration lands on edge k+present_ticks, so rx_code, rx_new, rx_full and guard_out change there, rx_new clears one edge later and dly_steer rises on edge k+present_ticks+SETTLE_CYC. A tone whose last high sample is edge m releases dly_steer on edge m+absent_ticks+1. The bench drives and samples on falling edges and counts exactly that many falling edges to land in the cycle just before and just after each of these edges; the vector table instead counts rx_new pulses over a whole tone-plus-pause window so that its result does not depend on where inside the window the pulse falls.

// File: rtl/tsv_pkg.sv
package tsv_pkg;

  typedef enum logic [0:0] {
    ST_WAIT_TONE = 1'b0,
    ST_HOLD      = 1'b1
  } steer_st_t;

  // A guard interval is met once at least one qualifying sample has been
  // counted and the count has reached the programmed limit.
  function automatic logic guard_met(input logic [31:0] cnt,
                                     input logic [31:0] lim);
    return (cnt != 32'd0) && (cnt >= lim);
  endfunction

endpackage

// File: rtl/tsv_guard_timer.sv
module tsv_guard_timer
  import tsv_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             level_in,
  input  logic             hold_clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic match;

  generate
    if (ACTIVE_HIGH) begin : g_high
      assign match = level_in;
    end else begin : g_low
      assign match = ~level_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!match || hold_clr) begin
      cnt <= '0;
    end else if (tick && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = guard_met(32'(cnt), 32'(limit));

  AST_CNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> $past(tick)); // R10

  AST_CNT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $past(match)); // R3

endmodule

// File: rtl/tsv_settle.sv
module tsv_settle #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic flag
);

  localparam int SW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] LOAD = SW'((SETTLE_CYC < 1) ? 1 : SETTLE_CYC);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (abort) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (start) begin
      cnt  <= LOAD;
      flag <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == SW'(1)) flag <= 1'b1;
    end
  end

  AST_SETTLE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !flag); // R5

endmodule

// File: rtl/tsv_steer_fsm.sv
module tsv_steer_fsm
  import tsv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pres_done,
  input  logic abs_done,
  input  logic cp_mode,
  input  logic est_q,
  output logic latch_evt,
  output logic exit_evt,
  output logic in_hold
);

  steer_st_t state;

  assign latch_evt = (state == ST_WAIT_TONE) && pres_done && !cp_mode;
  assign exit_evt  = (state == ST_HOLD) && abs_done;
  assign in_hold   = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_WAIT_TONE;
    end else begin
      unique case (state)
        ST_WAIT_TONE: if (latch_evt) state <= ST_HOLD;
        ST_HOLD:      if (exit_evt)  state <= ST_WAIT_TONE;
        default:      state <= ST_WAIT_TONE;
      endcase
    end
  end

  AST_EXIT_ON_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |-> !est_q); // R7

endmodule

// File: rtl/tone_steer_validator.sv
module tone_steer_validator
  import tsv_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              est_in,
  input  logic [CODE_W-1:0] tone_code,
  input  logic              cp_mode,
  input  logic              stat_rd,
  input  logic [CNT_W-1:0]  present_ticks,
  input  logic [CNT_W-1:0]  absent_ticks,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_new,
  output logic              rx_full,
  output logic              guard_out,
  output logic              dly_steer
);

  logic              est_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  pres_cnt;
  logic [CNT_W-1:0]  abs_cnt;
  logic              pres_done;
  logic              abs_done;
  logic              latch_evt;
  logic              exit_evt;
  logic              in_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      est_q  <= 1'b0;
      code_q <= '0;
    end else begin
      est_q <= est_in;
      if (est_in) code_q <= tone_code;
    end
  end

  tsv_guard_timer #(.CNT_W(CNT_W), .ACTIVE_HIGH(1'b1)) u_pres (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level_in(est_in),
    .hold_clr(cp_mode), .limit(present_ticks), .cnt(pres_cnt), .done(pres_done)
  );

  tsv_guard_timer #(.CNT_W(CNT_W), .ACTIVE_HIGH(1'b0)) u_abs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level_in(est_in),
    .hold_clr(1'b0), .limit(absent_ticks), .cnt(abs_cnt), .done(abs_done)
  );

  tsv_steer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pres_done(pres_done), .abs_done(abs_done),
    .cp_mode(cp_mode), .est_q(est_q), .latch_evt(latch_evt),
    .exit_evt(exit_evt), .in_hold(in_hold)
  );

  tsv_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(latch_evt), .abort(exit_evt),
    .flag(dly_steer)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_code <= '0;
      rx_new  <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      rx_new <= latch_evt;
      if (latch_evt) begin
        rx_code <= code_q;
        rx_full <= 1'b1;
      end else if (stat_rd) begin
        rx_full <= 1'b0;
      end
    end
  end

  assign guard_out = in_hold && est_q;

  AST_RX_NEW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |=> !rx_new); // R2

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_code != $past(rx_code)) |-> rx_new); // R3

  AST_FLAG_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dly_steer) |-> $stable(rx_code)); // R5

  AST_FALL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dly_steer) |-> !$past(est_in)); // R7

  AST_FULL_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |-> rx_full); // R8

  AST_CP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |-> !$past(cp_mode)); // R9

endmodule

// File: tb/sim_tone_steer_validator.sv
module sim_tone_steer_validator;

  localparam int P      = 6;
  localparam int A      = 4;
  localparam int SETTLE = 3;
  localparam int GAP    = 14;
  localparam int NV     = 8;

  localparam int V_CODE [NV] = '{5, 9, 10, 3, 15, 7, 0, 12};
  localparam int V_LEN  [NV] = '{6, 5, 12, 1, 6, 20, 2, 7};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        est_in = 1'b0;
  logic [3:0]  tone_code = '0;
  logic        cp_mode = 1'b0;
  logic        stat_rd = 1'b0;
  logic [15:0] present_ticks = 16'(P);
  logic [15:0] absent_ticks = 16'(A);
  logic [3:0]  rx_code;
  logic        rx_new, rx_full, guard_out, dly_steer;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tone_steer_validator #(.CODE_W(4), .CNT_W(16), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .est_in(est_in),
    .tone_code(tone_code), .cp_mode(cp_mode), .stat_rd(stat_rd),
    .present_ticks(present_ticks), .absent_ticks(absent_ticks),
    .rx_code(rx_code), .rx_new(rx_new), .rx_full(rx_full),
    .guard_out(guard_out), .dly_steer(dly_steer)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tone of len samples, then gap samples of silence; counts rx_new pulses.
  task automatic play(input int code, input int len, input int gap,
                      output int pulses);
    pulses = 0;
    est_in = 1'b1;
    tone_code = 4'(code);
    repeat (len) begin
      @(negedge clk);
      pulses += int'(rx_new);
    end
    est_in = 1'b0;
    tone_code = ~4'(code);
    repeat (gap) begin
      @(negedge clk);
      pulses += int'(rx_new);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pulses;
    int cnt;
    int exp_code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rx_code", int'(rx_code), 0);
    check("R1 rx_new", int'(rx_new), 0);
    check("R1 rx_full", int'(rx_full), 0);
    check("R1 guard_out", int'(guard_out), 0);
    check("R1 dly_steer", int'(dly_steer), 0);

    // Vector table: R2 for long-enough tones, R3 for short ones
    exp_code = 0;
    for (int i = 0; i < NV; i++) begin
      play(V_CODE[i], V_LEN[i], GAP, pulses);
      if (V_LEN[i] >= P) exp_code = V_CODE[i];
      check((V_LEN[i] >= P) ? "R2 pulses" : "R3 pulses", pulses,
            (V_LEN[i] >= P) ? 1 : 0);
      check((V_LEN[i] >= P) ? "R2 rx_code" : "R3 rx_code", int'(rx_code), exp_code);
    end

    // Exact registration timing
    est_in = 1'b1;
    tone_code = 4'd6;
    repeat (P) @(negedge clk);
    check("R2 no pulse before guard", int'(rx_new), 0);
    check("R3 code kept before guard", int'(rx_code), 12);
    @(negedge clk);
    check("R2 pulse at latch", int'(rx_new), 1);
    check("R2 code at latch", int'(rx_code), 6);
    check("R4 guard at latch", int'(guard_out), 1);
    check("R8 full at latch", int'(rx_full), 1);
    check("R5 flag low at latch", int'(dly_steer), 0);
    @(negedge clk);
    check("R2 pulse one cycle", int'(rx_new), 0);
    repeat (SETTLE - 2) @(negedge clk);
    check("R5 flag before settle", int'(dly_steer), 0);
    @(negedge clk);
    check("R5 flag after settle", int'(dly_steer), 1);

    // Long hold: one registration only
    cnt = 0;
    repeat (30) begin
      @(negedge clk);
      cnt += int'(rx_new);
    end
    check("R11 no repeat pulse", cnt, 0);
    check("R4 guard during hold", int'(guard_out), 1);

    // Dropout shorter than absent guard
    est_in = 1'b0;
    @(negedge clk);
    check("R4 guard drops with tone", int'(guard_out), 0);
    repeat (A - 2) @(negedge clk);
    est_in = 1'b1;
    tone_code = 4'd1;
    cnt = 0;
    pulses = 0;
    repeat (12) begin
      @(negedge clk);
      cnt += int'(!dly_steer);
      pulses += int'(rx_new);
    end
    check("R6 flag held through dropout", cnt, 0);
    check("R6 no new char", pulses, 0);
    check("R6 code unchanged", int'(rx_code), 6);
    check("R4 guard back", int'(guard_out), 1);

    // Valid pause
    est_in = 1'b0;
    repeat (A) @(negedge clk);
    check("R7 flag before absent guard", int'(dly_steer), 1);
    @(negedge clk);
    check("R7 flag falls", int'(dly_steer), 0);

    // Status read clears full
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R8 cleared by read", int'(rx_full), 0);

    // Read coinciding with registration: set wins
    est_in = 1'b1;
    tone_code = 4'd9;
    repeat (P) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R8 set wins pulse", int'(rx_new), 1);
    check("R8 set wins full", int'(rx_full), 1);
    est_in = 1'b0;
    repeat (GAP) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R8 cleared again", int'(rx_full), 0);

    // Call-progress mode
    cp_mode = 1'b1;
    play(3, 20, GAP, pulses);
    check("R9 no pulse", pulses, 0);
    check("R9 code kept", int'(rx_code), 9);
    check("R9 full stays clear", int'(rx_full), 0);
    cp_mode = 1'b0;

    // Timebase stopped
    tick = 1'b0;
    play(4, 20, GAP, pulses);
    check("R10 no tick no pulse", pulses, 0);
    check("R10 code kept", int'(rx_code), 9);
    tick = 1'b1;
    play(4, P, GAP, pulses);
    check("R10 tick restored", pulses, 1);
    check("R10 code loaded", int'(rx_code), 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule